// File: doc/BRIEF.md
# Infrared Transmitter Host Port

This block is the processor-facing side of an infrared frame transmitter. A host reaches it over a synchronous parallel port made of active-low select, write and read-enable strobes, a 2-bit register address, a 32-bit write bus and a 32-bit read bus. Behind the port sit a transmit queue of 32 words of 32 bits, a configuration register and a read-only status word.

The host loads payload words into the queue, then writes the configuration register with a block length, the interrupt enable and the start bit. The transmitter core, which does the serial encoding, receives a one-cycle start pulse and the block length. It pops words with a read strobe and reports back through a busy level and a one-cycle done pulse. When the done pulse arrives with interrupts enabled, an interrupt line rises and stays up until the host clears it.

The start, interrupt-clear and queue-clear bits act only at the moment they are written and are never stored. The status word shows the queue fill state and the transmitter busy level.

Top module: `irtx_host_port`

## Requirements
- R1: A write takes effect on a rising clock edge when `bus_cs_n` and `bus_we_n` are both low. Address 2'b01 is the configuration register (read/write). Address 2'b10 is the queue write port, which reads as zero. Address 2'b11 is the status word, which is read-only. A write to address 2'b00 or to 2'b11 changes nothing, and address 2'b00 reads as zero.
- R2: `bus_rdata_oe` is high, and `bus_rdata` carries the selected register, only while `bus_cs_n` and `bus_oe_n` are both low. At all other times `bus_rdata` is zero.
- R3: Reading the configuration register returns the interrupt enable at bit 10 and the block length at bits 4:0. Every other bit reads zero, including bits 12, 11 and 9. `tx_blk_len` always equals the stored length.
- R4: Writing the configuration register with bit 12 set raises `tx_start` for exactly the one cycle that follows the write edge. The bit is not stored.
- R5: The status word has full at bit 3, half full (16 or more words held) at bit 2, empty at bit 1, and at bit 0 the level of `tx_busy`. Bits 31:4 read zero.
- R6: The queue holds 32 words and gives them back in write order. `tx_fifo_data` shows the oldest word, and a high `tx_fifo_rd` at a clock edge removes that word. A pop while the queue is empty does nothing. `tx_fifo_empty` matches status bit 1.
- R7: A queue write while the queue holds 32 words is dropped. Neither the contents nor the count change.
- R8: Writing the configuration register with bit 9 set empties the queue at that edge. The bit is not stored.
- R9: `tx_irq` rises on the edge where `tx_done` is high and the interrupt enable is 1. With the enable at 0, `tx_done` leaves `tx_irq` low.
- R10: `tx_irq` stays high until a configuration write sets bit 11 or clears bit 10. If `tx_done` arrives in the same cycle as a clearing write that keeps the enable, the interrupt stays high.
- R11: An asynchronous active-low `rst_n` empties the queue, zeroes the configuration, and drops `tx_irq` and `tx_start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_cs_n | input | 1 | Port select, active low |
| bus_we_n | input | 1 | Write strobe, active low |
| bus_oe_n | input | 1 | Read enable, active low |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 32 | Write data from host |
| bus_rdata | output | 32 | Read data to host, zero when not enabled |
| bus_rdata_oe | output | 1 | High while the port drives read data |
| tx_busy | input | 1 | Transmitter is sending a frame |
| tx_done | input | 1 | One-cycle pulse at end of frame |
| tx_fifo_rd | input | 1 | Pop strobe from transmitter |
| tx_fifo_data | output | 32 | Oldest queued word |
| tx_fifo_empty | output | 1 | Queue holds no words |
| tx_start | output | 1 | One-cycle frame start pulse |
| tx_blk_len | output | 5 | Block length from configuration |
| tx_irq | output | 1 | End-of-frame interrupt |

## Verification
The hardest conditions to reach are a done pulse that lands in the same cycle as an interrupt-clear write, and a write offered to a queue that is already full. The bench drives the done strobe by hand at the same clock edge as the clearing write, so the two meet deliberately. It also sweeps the fill level one word at a time from empty to past full. At every step it compares the status word against flags computed from the count, then drains the queue and checks that the dropped word never appears.

// File: rtl/irtx_pkg.sv
package irtx_pkg;

   typedef enum logic [1:0] {
      ADDR_NONE = 2'b00,
      ADDR_CFG  = 2'b01,
      ADDR_FIFO = 2'b10,
      ADDR_STAT = 2'b11
   } reg_addr_e;

   localparam int CFG_START_BIT  = 12;
   localparam int CFG_IRQCLR_BIT = 11;
   localparam int CFG_IRQEN_BIT  = 10;
   localparam int CFG_FLUSH_BIT  = 9;

   localparam int NUM_ADDR = 4;

   typedef struct packed {
      logic full;
      logic half;
      logic empty;
      logic busy;
   } stat_t;

endpackage

// File: rtl/irtx_bus_decode.sv
module irtx_bus_decode
   import irtx_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              we_n,
   input  logic              oe_n,
   input  logic [1:0]        addr,
   input  logic [DATA_W-1:0] cfg_word,
   input  logic [DATA_W-1:0] stat_word,
   output logic              wr_cfg,
   output logic              wr_fifo,
   output logic              rd_oe,
   output logic [DATA_W-1:0] rdata
);

   logic [NUM_ADDR-1:0] sel;

   for (genvar i = 0; i < NUM_ADDR; i++) begin : g_sel
      assign sel[i] = !cs_n && (addr == i[1:0]);
   end

   assign wr_cfg  = sel[ADDR_CFG]  && !we_n;
   assign wr_fifo = sel[ADDR_FIFO] && !we_n;
   assign rd_oe   = !cs_n && !oe_n;

   always_comb begin
      rdata = '0;
      if (rd_oe) begin
         if (sel[ADDR_CFG])  rdata = cfg_word;
         if (sel[ADDR_STAT]) rdata = stat_word;
      end
   end

   AST_RDATA_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !(!cs_n && !oe_n) |-> rdata == '0); // R2
   AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(sel)); // R1

endmodule

// File: rtl/irtx_sync_fifo.sv
module irtx_sync_fifo #(
   parameter int WIDTH     = 32,
   parameter int DEPTH     = 32,
   parameter bit REG_FLAGS = 1'b1,
   localparam int AW       = $clog2(DEPTH),
   localparam int CW       = AW + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             wr_en,
   input  logic [WIDTH-1:0] wr_data,
   input  logic             rd_en,
   output logic [WIDTH-1:0] rd_data,
   output logic [CW-1:0]    count,
   output logic             full,
   output logic             half,
   output logic             empty
);

   localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
   localparam logic [CW-1:0] HALF_CNT = CW'(DEPTH / 2);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("irtx_sync_fifo: DEPTH must be a power of two, at least 2");
   end

   logic [WIDTH-1:0] mem [DEPTH];
   logic [AW-1:0]    wptr, rptr;
   logic [CW-1:0]    cnt_q, cnt_nxt;
   logic             do_wr, do_rd;
   logic             full_c, empty_c;

   assign full_c  = (cnt_q == FULL_CNT);
   assign empty_c = (cnt_q == '0);
   assign do_wr   = wr_en && !full_c && !flush;
   assign do_rd   = rd_en && !empty_c && !flush;

   always_comb begin
      if (flush) cnt_nxt = '0;
      else       cnt_nxt = cnt_q + CW'(do_wr) - CW'(do_rd);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr  <= '0;
         rptr  <= '0;
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_nxt;
         if (flush) begin
            wptr <= '0;
            rptr <= '0;
         end else begin
            if (do_wr) wptr <= wptr + 1'b1;
            if (do_rd) rptr <= rptr + 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (do_wr) mem[wptr] <= wr_data;
   end

   assign rd_data = mem[rptr];
   assign count   = cnt_q;

   if (REG_FLAGS) begin : g_reg_flags
      logic full_q, half_q, empty_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            full_q  <= 1'b0;
            half_q  <= 1'b0;
            empty_q <= 1'b1;
         end else begin
            full_q  <= (cnt_nxt == FULL_CNT);
            half_q  <= (cnt_nxt >= HALF_CNT);
            empty_q <= (cnt_nxt == '0);
         end
      end
      assign full  = full_q;
      assign half  = half_q;
      assign empty = empty_q;
   end else begin : g_comb_flags
      assign full  = full_c;
      assign half  = (cnt_q >= HALF_CNT);
      assign empty = empty_c;
   end

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      count <= FULL_CNT); // R6
   AST_FULL_WR_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      full && wr_en && !rd_en && !flush |=> $stable(count)); // R7
   AST_EMPTY_RD_NOP: assert property (@(posedge clk) disable iff (!rst_n)
      empty && rd_en && !wr_en && !flush |=> $stable(count)); // R6
   AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> empty); // R8

endmodule

// File: rtl/irtx_cfg_regs.sv
module irtx_cfg_regs
   import irtx_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int LEN_W  = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_cfg,
   input  logic [DATA_W-1:0] wdata,
   input  logic              tx_done,
   output logic              start,
   output logic              flush,
   output logic              irq,
   output logic [LEN_W-1:0]  blk_len,
   output logic [DATA_W-1:0] cfg_word
);

   if (LEN_W < 1 || LEN_W > CFG_FLUSH_BIT) begin : g_bad_len
      $error("irtx_cfg_regs: LEN_W must lie below the control bits");
   end

   logic             ie_q, ie_nxt;
   logic [LEN_W-1:0] len_q;
   logic             start_q, irq_q, clr;

   assign clr    = wr_cfg && wdata[CFG_IRQCLR_BIT];
   assign flush  = wr_cfg && wdata[CFG_FLUSH_BIT];
   assign ie_nxt = wr_cfg ? wdata[CFG_IRQEN_BIT] : ie_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ie_q    <= 1'b0;
         len_q   <= '0;
         start_q <= 1'b0;
         irq_q   <= 1'b0;
      end else begin
         ie_q    <= ie_nxt;
         start_q <= wr_cfg && wdata[CFG_START_BIT];
         irq_q   <= ie_nxt && (tx_done || (irq_q && !clr));
         if (wr_cfg) len_q <= wdata[LEN_W-1:0];
      end
   end

   always_comb begin
      cfg_word                = '0;
      cfg_word[LEN_W-1:0]     = len_q;
      cfg_word[CFG_IRQEN_BIT] = ie_q;
   end

   assign start   = start_q;
   assign irq     = irq_q;
   assign blk_len = len_q;

   AST_START_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> $past(wr_cfg && wdata[CFG_START_BIT])); // R4
   AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> cfg_word[CFG_IRQEN_BIT]); // R9
   AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      irq && !wr_cfg |=> irq); // R10
   AST_IRQ_RISE_SRC: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $past(tx_done)); // R9

endmodule

// File: rtl/irtx_host_port.sv
module irtx_host_port
   import irtx_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter int FIFO_DEPTH = 32,
   parameter int LEN_W      = 5,
   parameter bit REG_FLAGS  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_cs_n,
   input  logic              bus_we_n,
   input  logic              bus_oe_n,
   input  logic [1:0]        bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              bus_rdata_oe,
   input  logic              tx_busy,
   input  logic              tx_done,
   input  logic              tx_fifo_rd,
   output logic [DATA_W-1:0] tx_fifo_data,
   output logic              tx_fifo_empty,
   output logic              tx_start,
   output logic [LEN_W-1:0]  tx_blk_len,
   output logic              tx_irq
);

   localparam int CW = $clog2(FIFO_DEPTH) + 1;

   if (DATA_W <= CFG_START_BIT) begin : g_bad_width
      $error("irtx_host_port: DATA_W too narrow for the control bits");
   end

   logic              wr_cfg, wr_fifo, flush;
   logic [DATA_W-1:0] cfg_word, stat_word;
   logic [CW-1:0]     fifo_count;
   stat_t             st;

   irtx_bus_decode #(.DATA_W(DATA_W)) u_dec (
      .clk       (clk),
      .rst_n     (rst_n),
      .cs_n      (bus_cs_n),
      .we_n      (bus_we_n),
      .oe_n      (bus_oe_n),
      .addr      (bus_addr),
      .cfg_word  (cfg_word),
      .stat_word (stat_word),
      .wr_cfg    (wr_cfg),
      .wr_fifo   (wr_fifo),
      .rd_oe     (bus_rdata_oe),
      .rdata     (bus_rdata)
   );

   irtx_cfg_regs #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_cfg (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_cfg   (wr_cfg),
      .wdata    (bus_wdata),
      .tx_done  (tx_done),
      .start    (tx_start),
      .flush    (flush),
      .irq      (tx_irq),
      .blk_len  (tx_blk_len),
      .cfg_word (cfg_word)
   );

   irtx_sync_fifo #(
      .WIDTH     (DATA_W),
      .DEPTH     (FIFO_DEPTH),
      .REG_FLAGS (REG_FLAGS)
   ) u_fifo (
      .clk     (clk),
      .rst_n   (rst_n),
      .flush   (flush),
      .wr_en   (wr_fifo),
      .wr_data (bus_wdata),
      .rd_en   (tx_fifo_rd),
      .rd_data (tx_fifo_data),
      .count   (fifo_count),
      .full    (st.full),
      .half    (st.half),
      .empty   (st.empty)
   );

   assign st.busy       = tx_busy;
   assign tx_fifo_empty = st.empty;

   always_comb begin
      stat_word      = '0;
      stat_word[3:0] = st;
   end

   AST_EMPTY_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      tx_fifo_empty == (fifo_count == '0)); // R6
   AST_FULL_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      st.full == (fifo_count == CW'(FIFO_DEPTH))); // R5

endmodule

// File: tb/tb_irtx_host_port.sv
module tb_irtx_host_port;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_cs_n = 1'b1, bus_we_n = 1'b1, bus_oe_n = 1'b1;
   logic [1:0]  bus_addr = 2'b00;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        bus_rdata_oe;
   logic        tx_busy = 1'b0, tx_done = 1'b0, tx_fifo_rd = 1'b0;
   logic [31:0] tx_fifo_data;
   logic        tx_fifo_empty, tx_start, tx_irq;
   logic [4:0]  tx_blk_len;

   int n_chk = 0;
   int n_fail = 0;

   always #10 clk = ~clk;

   irtx_host_port dut (
      .clk(clk), .rst_n(rst_n),
      .bus_cs_n(bus_cs_n), .bus_we_n(bus_we_n), .bus_oe_n(bus_oe_n),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .bus_rdata_oe(bus_rdata_oe),
      .tx_busy(tx_busy), .tx_done(tx_done), .tx_fifo_rd(tx_fifo_rd),
      .tx_fifo_data(tx_fifo_data), .tx_fifo_empty(tx_fifo_empty),
      .tx_start(tx_start), .tx_blk_len(tx_blk_len), .tx_irq(tx_irq)
   );

   task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_cs_n = 1'b0; bus_we_n = 1'b0; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_cs_n = 1'b1; bus_we_n = 1'b1;
   endtask

   task automatic bus_read(input logic [1:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_cs_n = 1'b0; bus_oe_n = 1'b0; bus_addr = a;
      #2 d = bus_rdata;
      bus_cs_n = 1'b1; bus_oe_n = 1'b1;
   endtask

   task automatic pulse_rd();
      @(negedge clk); tx_fifo_rd = 1'b1;
      @(negedge clk); tx_fifo_rd = 1'b0;
   endtask

   task automatic pulse_done();
      @(negedge clk); tx_done = 1'b1;
      @(negedge clk); tx_done = 1'b0;
   endtask

   function automatic logic [31:0] word_of(input int k);
      return (32'(k) * 32'h0101_0101) ^ 32'hA5C3_0000;
   endfunction

   function automatic logic [31:0] stat_of(input int cnt, input logic busy);
      return {28'd0, cnt == 32, cnt >= 16, cnt == 0, busy};
   endfunction

   initial begin
      #(200000 * 20);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      logic [31:0] rd;
      repeat (3) @(negedge clk);
      // R11 reset state
      check({31'd0, tx_irq}, 32'd0, "R11 irq in reset");
      check({31'd0, tx_start}, 32'd0, "R11 start in reset");
      rst_n = 1'b1;
      bus_read(2'b11, rd); check(rd, 32'h2, "R11 status after reset");
      bus_read(2'b01, rd); check(rd, 32'h0, "R11 config after reset");

      // R2 output enable gating
      @(negedge clk);
      bus_cs_n = 1'b0; bus_oe_n = 1'b1; bus_addr = 2'b11; #2;
      check({31'd0, bus_rdata_oe}, 32'd0, "R2 oe high gives no drive");
      check(bus_rdata, 32'd0, "R2 rdata zero when not enabled");
      bus_cs_n = 1'b1; bus_oe_n = 1'b0; #2;
      check({31'd0, bus_rdata_oe}, 32'd0, "R2 cs high gives no drive");
      check(bus_rdata, 32'd0, "R2 rdata zero with cs high");
      bus_oe_n = 1'b1;

      // R1 write with select high has no effect
      @(negedge clk);
      bus_cs_n = 1'b1; bus_we_n = 1'b0; bus_addr = 2'b10; bus_wdata = 32'h1234;
      @(negedge clk); bus_we_n = 1'b1;
      bus_read(2'b11, rd); check(rd, 32'h2, "R1 unselected write ignored");

      // R5 R7 fill sweep 1..33
      for (int k = 1; k <= 33; k++) begin
         bus_write(2'b10, word_of(k));
         bus_read(2'b11, rd);
         check(rd, stat_of((k > 32) ? 32 : k, 1'b0), "R5 R7 status during fill");
      end
      bus_read(2'b10, rd); check(rd, 32'd0, "R1 queue port reads zero");

      // R6 drain in order, word 33 never appears
      for (int i = 1; i <= 32; i++) begin
         check(tx_fifo_data, word_of(i), "R6 order of queued words");
         pulse_rd();
      end
      check({31'd0, tx_fifo_empty}, 32'd1, "R7 dropped word absent");
      pulse_rd();
      bus_read(2'b11, rd); check(rd, 32'h2, "R6 pop on empty is no-op");
      bus_write(2'b10, 32'hCAFE_0001);
      check(tx_fifo_data, 32'hCAFE_0001, "R6 queue usable after empty pop");
      pulse_rd();

      // R8 clear queue
      for (int k = 0; k < 5; k++) bus_write(2'b10, word_of(k + 40));
      bus_write(2'b01, 32'h0000_0200);
      bus_read(2'b11, rd); check(rd, 32'h2, "R8 clear empties queue");
      bus_read(2'b01, rd); check(rd, 32'h0, "R8 clear bit not stored");

      // R3 R4 config and start pulse
      bus_write(2'b01, 32'h0000_1410);
      check({31'd0, tx_start}, 32'd1, "R4 start pulse after write");
      @(negedge clk);
      check({31'd0, tx_start}, 32'd0, "R4 start lasts one cycle");
      bus_read(2'b01, rd); check(rd, 32'h0000_0410, "R3 R4 readback without start");
      check({27'd0, tx_blk_len}, 32'h10, "R3 block length output");
      bus_write(2'b01, 32'hFFFF_FFFF);
      bus_read(2'b01, rd); check(rd, 32'h0000_041F, "R3 only enable and length kept");

      // R1 address 00 and status writes ignored
      bus_write(2'b00, 32'h0000_0000);
      bus_write(2'b11, 32'h0000_0000);
      bus_read(2'b01, rd); check(rd, 32'h0000_041F, "R1 write to 00 or 11 ignored");
      bus_read(2'b00, rd); check(rd, 32'h0, "R1 address 00 reads zero");

      // R5 busy bit with half full
      tx_busy = 1'b1;
      bus_read(2'b11, rd); check(rd, stat_of(0, 1'b1), "R5 busy with empty queue");
      for (int k = 0; k < 16; k++) bus_write(2'b10, word_of(k));
      bus_read(2'b11, rd); check(rd, stat_of(16, 1'b1), "R5 busy with half full");
      bus_write(2'b10, 32'h0);
      bus_read(2'b11, rd); check(rd, stat_of(17, 1'b1), "R5 above half");
      tx_busy = 1'b0;
      bus_write(2'b01, 32'h0000_0200);

      // R9 R10 interrupt
      bus_write(2'b01, 32'h0000_0400);
      pulse_done();
      check({31'd0, tx_irq}, 32'd1, "R9 irq rises on done");
      repeat (4) @(negedge clk);
      check({31'd0, tx_irq}, 32'd1, "R10 irq holds");
      bus_write(2'b01, 32'h0000_0C00);
      check({31'd0, tx_irq}, 32'd0, "R10 clear bit drops irq");
      bus_read(2'b01, rd); check(rd, 32'h0000_0400, "R10 clear keeps enable");
      pulse_done();
      check({31'd0, tx_irq}, 32'd1, "R9 irq rises again");
      bus_write(2'b01, 32'h0000_0000);
      check({31'd0, tx_irq}, 32'd0, "R10 disable drops irq");
      pulse_done();
      check({31'd0, tx_irq}, 32'd0, "R9 no irq when disabled");
      // R10 coincident done and clear: set wins
      bus_write(2'b01, 32'h0000_0400);
      pulse_done();
      @(negedge clk);
      bus_cs_n = 1'b0; bus_we_n = 1'b0; bus_addr = 2'b01;
      bus_wdata = 32'h0000_0C00; tx_done = 1'b1;
      @(negedge clk);
      bus_cs_n = 1'b1; bus_we_n = 1'b1; tx_done = 1'b0;
      check({31'd0, tx_irq}, 32'd1, "R10 done beats clear");

      // R11 asynchronous reset mid-cycle
      bus_write(2'b10, 32'h1);
      #3 rst_n = 1'b0; #1;
      check({31'd0, tx_irq}, 32'd0, "R11 async reset drops irq");
      check({31'd0, tx_fifo_empty}, 32'd1, "R11 async reset empties queue");
      @(negedge clk); rst_n = 1'b1;
      bus_read(2'b01, rd); check(rd, 32'h0, "R11 config cleared");

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule